// File: doc/BRIEF.md
# Accumulator ALU with Carry/Overflow Flag Register

This block is the arithmetic and logic unit of a small accumulator machine. Each operation takes an accumulator byte, a second byte, a shift count and an operation code. It returns one result byte and a flag that says whether the result goes to the named register or to the accumulator. The block keeps its own carry and overflow flag register. Only the carry-aware operations change that register. Every other operation leaves both flags as they were.

Operations enter on a valid/ready request port and leave on a valid/ready result port. The result port has one register stage, and the flag register is updated in the same cycle as that stage. The flags shown at the ports therefore always belong to the result that is currently on the result port.

Back-pressure works as follows. `in_ready` is high when the result stage is empty or is being drained in the same cycle (`!out_valid || out_ready`). A request is accepted on a clock edge where `in_valid && in_ready`. A result that is held with `out_ready` low keeps its value, its destination flag and its flags unchanged until it is taken.

Top module: `acc_alu`

## Requirements
- R1: Code 0 (plain add) gives (A+B) mod 256 and code 2 (plain subtract) gives (A-B) mod 256. Neither changes the carry or overflow flag.
- R2: Code 1 (add with carry) gives A+B+CF. CF becomes the carry out of bit 7. VF becomes 1 exactly when A and B have the same sign bit and the result's sign bit differs from it.
- R3: Code 3 (subtract with carry) gives A-B-1+CF, computed as A+~B+CF. CF becomes the carry out of that sum, so CF=1 means no borrow. VF follows the R2 rule with ~B as the second operand.
- R4: Code 4 gives A AND B, code 5 gives NOT(A OR B) and code 6 gives A XOR B. All three leave the flags unchanged.
- R5: Code 7 shifts A right and code 8 shifts A left, by the count `in_shamt` (0 to 7). Vacated bits are filled with 0 and the flags are unchanged.
- R6: Code 9 shifts A right and code 10 shifts A left through carry by `in_shamt`. Vacated bits are filled with the old CF. CF becomes the last bit shifted out, and VF is always cleared. A count of 0 leaves A and CF unchanged and clears VF.
- R7: Code 11 (register add with carry) treats `in_b` as the register value and `in_a` as the immediate. It gives B+A+CF, updates CF and VF as in R2, and sets `out_to_reg` to 1. Every other code sets `out_to_reg` to 0.
- R8: Codes 12 to 15 pass A through unchanged and leave the flags unchanged.
- R9: While `rst_n` is low and after its release, `out_valid`, `out_cf` and `out_vf` are 0 and `in_ready` is 1.
- R10: `in_ready` equals `!out_valid || out_ready`. A held result (`out_valid` high with `out_ready` low) keeps its result, its destination flag and its flags stable until the cycle it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code, values as listed in R1 to R8 |
| in_a | input | W | Accumulator, or the immediate for code 11 |
| in_b | input | W | Register operand |
| in_shamt | input | $clog2(W) | Shift count |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken this cycle |
| out_result | output | W | Result byte |
| out_to_reg | output | 1 | 1: the result goes to the named register; 0: it goes to the accumulator |
| out_cf | output | 1 | Carry flag after the held result |
| out_vf | output | 1 | Overflow flag after the held result |

## Verification
The bench builds the block with the default W=8, so the shift count is 3 bits wide and every count from 0 to 7 can be reached, including the zero-count carry case and the full seven-place shift. At this width a mix of directed corner values and random operands covers the signed-overflow boundaries (0x7F, 0x80, 0xFF) for both carry-in values. It also lets carry chains run across successive operations, because the flags set by one operation feed the next one. A random `out_ready` stretches held results over several cycles, which exercises the back-pressure rule.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_NOR  = 4'd5,
    OP_XOR  = 4'd6,
    OP_SHR  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHRC = 4'd9,
    OP_SHLC = 4'd10,
    OP_ADCR = 4'd11
  } alu_op_e;
endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    // signed overflow: the two inputs agree in sign and the sum does not
    ovf  = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
  end
endmodule

// File: rtl/acc_bitwise.sv
module acc_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  always_comb begin
    case (sel)
      2'd0:    y = a & b;
      2'd1:    y = (a | b) ^ {W{1'b1}};
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/acc_shift.sv
module acc_shift #(
  parameter int W    = 8,
  parameter bit LEFT = 1'b0,
  localparam int SW  = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] n,
  input  logic          fill,
  output logic [W-1:0]  y,
  output logic          last
);
  always_comb begin
    y    = '0;
    last = 1'b0;
    for (int i = 0; i < W; i++) begin
      y[i] = fill;
      for (int j = 0; j < W; j++) begin
        if (LEFT ? (j == i - int'(n)) : (j == i + int'(n))) y[i] = a[j];
      end
    end
    for (int j = 0; j < W; j++) begin
      if (n != '0) begin
        if (LEFT ? (j == W - int'(n)) : (j == int'(n) - 1)) last = a[j];
      end
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W   = 8,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [SW-1:0] in_shamt,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_result,
  output logic          out_to_reg,
  output logic          out_cf,
  output logic          out_vf
);
  alu_op_e op;
  logic          accept;
  logic          cf_q, vf_q;
  logic [W-1:0]  add_b;
  logic          add_cin;
  logic [W-1:0]  add_sum;
  logic          add_cout, add_ovf;
  logic [W-1:0]  bw_y;
  logic [1:0]    bw_sel;
  logic          carry_shift;
  logic [W-1:0]  sh_y   [2];
  logic          sh_last[2];
  logic [W-1:0]  res_n;
  logic          cf_n, vf_n, to_reg_n;

  assign op       = alu_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign out_cf   = cf_q;
  assign out_vf   = vf_q;

  // one shared adder; subtraction feeds the inverted operand
  always_comb begin
    add_b   = in_b;
    add_cin = cf_q;
    case (op)
      OP_ADD: add_cin = 1'b0;
      OP_SUB: begin add_b = ~in_b; add_cin = 1'b1; end
      OP_SBC: add_b = ~in_b;
      default: ;
    endcase
  end

  acc_adder #(.W(W)) u_add (
    .a(in_a), .b(add_b), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  assign bw_sel = (op == OP_AND) ? 2'd0 : (op == OP_NOR) ? 2'd1 : 2'd2;

  acc_bitwise #(.W(W)) u_bw (.a(in_a), .b(in_b), .sel(bw_sel), .y(bw_y));

  assign carry_shift = (op == OP_SHRC) || (op == OP_SHLC);

  for (genvar d = 0; d < 2; d++) begin : g_dir
    acc_shift #(.W(W), .LEFT(d == 1)) u_sh (
      .a(in_a), .n(in_shamt), .fill(carry_shift & cf_q),
      .y(sh_y[d]), .last(sh_last[d])
    );
  end

  always_comb begin
    res_n    = in_a;
    cf_n     = cf_q;
    vf_n     = vf_q;
    to_reg_n = 1'b0;
    case (op)
      OP_ADD, OP_SUB: res_n = add_sum;
      OP_ADC, OP_SBC: begin
        res_n = add_sum; cf_n = add_cout; vf_n = add_ovf;
      end
      OP_ADCR: begin
        res_n = add_sum; cf_n = add_cout; vf_n = add_ovf; to_reg_n = 1'b1;
      end
      OP_AND, OP_NOR, OP_XOR: res_n = bw_y;
      OP_SHR: res_n = sh_y[0];
      OP_SHL: res_n = sh_y[1];
      OP_SHRC: begin
        res_n = sh_y[0];
        cf_n  = (in_shamt == '0) ? cf_q : sh_last[0];
        vf_n  = 1'b0;
      end
      OP_SHLC: begin
        res_n = sh_y[1];
        cf_n  = (in_shamt == '0) ? cf_q : sh_last[1];
        vf_n  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_to_reg <= 1'b0;
      cf_q       <= 1'b0;
      vf_q       <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= res_n;
      out_to_reg <= to_reg_n;
      cf_q       <= cf_n;
      vf_q       <= vf_n;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W   = 8,
  localparam int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    in_op,
  input logic [W-1:0]  in_a,
  input logic [W-1:0]  in_b,
  input logic [SW-1:0] in_shamt,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_result,
  input logic          out_to_reg,
  input logic          out_cf,
  input logic          out_vf
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_plain_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 4'd0 || in_op == 4'd2 || (in_op >= 4'd4 && in_op <= 4'd8) || in_op >= 4'd12)
    |=> out_cf == $past(out_cf) && out_vf == $past(out_vf));

  a_r2_adc_sum: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd1
    |=> {out_cf, out_result} ==
        ({1'b0, $past(in_a)} + {1'b0, $past(in_b)} + (W+1)'($past(out_cf))));

  a_r6_shift_clears_vf: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 4'd9 || in_op == 4'd10) |=> !out_vf);

  a_r7_to_reg: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_to_reg == ($past(in_op) == 4'd11));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready
    |=> out_valid && $stable(out_result) && $stable(out_to_reg) && $stable(out_cf) && $stable(out_vf));

  a_r10_block: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r9_reset_state: assert property (@(posedge clk)
    !rst_n |-> !out_valid && !out_cf && !out_vf);
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_to_reg(out_to_reg), .out_cf(out_cf), .out_vf(out_vf)
);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_a = '0, in_b = '0;
  logic [2:0] in_shamt = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_result;
  logic       out_to_reg, out_cf, out_vf;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // expected entries: {tag, result, to_reg, cf, vf}
  int    q_res[$];
  bit    q_reg[$], q_cf[$], q_vf[$];
  string q_tag[$];
  bit    m_cf = 1'b0, m_vf = 1'b0;

  always #2 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_to_reg(out_to_reg), .out_cf(out_cf), .out_vf(out_vf)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 2:          return "R1";
      1:             return "R2";
      3:             return "R3";
      4, 5, 6:       return "R4";
      7, 8:          return "R5";
      9, 10:         return "R6";
      11:            return "R7";
      default:       return "R8";
    endcase
  endfunction

  // behavioural reference: push the expected outcome and advance model flags
  task automatic model(input int op, input int a, input int b, input int n);
    int r, t, bb;
    bit c, v, toreg;
    r = a; c = m_cf; v = m_vf; toreg = 0;
    case (op)
      0: r = (a + b) & 255;
      2: r = (a - b) & 255;
      1, 3, 11: begin
        bb = (op == 3) ? ((~b) & 255) : b;
        t  = a + bb + int'(m_cf);
        r  = t & 255;
        c  = (t >> 8) & 1;
        v  = (((a ^ r) & (bb ^ r) & 128) != 0);
        toreg = (op == 11);
      end
      4: r = a & b;
      5: r = (~(a | b)) & 255;
      6: r = a ^ b;
      7: r = a >> n;
      8: r = (a << n) & 255;
      9: begin
        r = a >> n;
        if (m_cf && n > 0) r = r | ((255 << (8 - n)) & 255);
        if (n > 0) c = (a >> (n - 1)) & 1;
        v = 0;
      end
      10: begin
        r = (a << n) & 255;
        if (m_cf) r = r | ((1 << n) - 1);
        if (n > 0) c = (a >> (8 - n)) & 1;
        v = 0;
      end
      default: ;
    endcase
    q_res.push_back(r); q_reg.push_back(toreg);
    q_cf.push_back(c); q_vf.push_back(v); q_tag.push_back(tag_of(op));
    m_cf = c; m_vf = v;
  endtask

  task automatic step(input bit v, input int op, input int a, input int b,
                      input int n, input bit rdy);
    bit take;
    @(negedge clk);
    if (out_valid) begin
      if (q_res.size() == 0) check("R10", 1, 0, "unexpected result");
      else begin
        check(q_tag[0], int'(out_result), q_res[0], "result");
        check(q_tag[0], int'(out_to_reg), int'(q_reg[0]), "to_reg (R7)");
        check(q_tag[0], int'(out_cf), int'(q_cf[0]), "cf");
        check(q_tag[0], int'(out_vf), int'(q_vf[0]), "vf");
      end
    end
    in_valid = v; in_op = 4'(op); in_a = 8'(a); in_b = 8'(b);
    in_shamt = 3'(n); out_ready = rdy;
    #1;
    check("R10", int'(in_ready), int'(!out_valid || rdy), "in_ready");
    take = out_valid && rdy;
    if (take && q_res.size() > 0) begin
      void'(q_res.pop_front()); void'(q_reg.pop_front());
      void'(q_cf.pop_front()); void'(q_vf.pop_front()); void'(q_tag.pop_front());
    end
    if (v && in_ready) model(op, a, b, n);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", int'(out_valid), 0, "out_valid in reset");
    check("R9", int'(out_cf), 0, "cf in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", int'(out_valid), 0, "out_valid after reset");
    check("R9", int'(out_vf), 0, "vf after reset");
    check("R9", int'(in_ready), 1, "in_ready after reset");

    // directed corners
    step(1, 1, 8'hFF, 8'h01, 0, 1);  // R2 carry out, no overflow
    step(1, 0, 8'h7F, 8'h01, 0, 1);  // R1 flags kept (cf stays 1)
    step(1, 1, 8'h7F, 8'h00, 0, 1);  // R2 0x7F+0+1 overflows
    step(1, 3, 8'h05, 8'h03, 0, 1);  // R3 no borrow
    step(1, 3, 8'h03, 8'h05, 0, 1);  // R3 borrow
    step(1, 3, 8'h80, 8'h01, 0, 1);  // R3 signed overflow
    step(1, 9, 8'hA5, 8'h00, 0, 1);  // R6 zero count
    step(1, 1, 8'hFF, 8'hFF, 0, 1);  // set CF
    step(1, 9, 8'h81, 8'h00, 7, 1);  // R6 right by 7, fill ones
    step(1, 10, 8'h40, 8'h00, 2, 1); // R6 left through carry
    step(1, 7, 8'hF0, 8'h00, 3, 1);  // R5
    step(1, 8, 8'h0F, 8'h00, 7, 1);  // R5
    step(1, 5, 8'h0C, 8'h30, 0, 1);  // R4 NOR
    step(1, 11, 8'h01, 8'hFF, 0, 1); // R7
    step(1, 13, 8'h5A, 8'h11, 0, 1); // R8
    step(1, 2, 8'h00, 8'h01, 0, 0);  // R1, held
    step(0, 0, 0, 0, 0, 0);          // R10 hold
    step(1, 6, 8'h33, 8'h0F, 0, 0);  // blocked request
    step(0, 0, 0, 0, 0, 1);

    for (int k = 0; k < 4000; k++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 7), $urandom_range(0, 3) != 0);

    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 1);
    check("R10", q_res.size(), 0, "queue drained");
    done = 1'b1;
    finish_run();
  end
endmodule